// File: doc/BRIEF.md
# Masked DES Round Engine

This block computes DES encryption of one 64-bit block while every intermediate value is kept as two shares. One share is the data word XORed with a random mask. The other share is that mask. The two shares sit in separate registers, and the true value is their XOR. A start pulse presents the plaintext and a 64-bit random initial mask. The engine then runs sixteen Feistel rounds, one per clock.

During each round the caller supplies the 48-bit round key on `round_key`. The key that goes with a round is chosen by `round_idx`. The caller also supplies 32 bits of fresh randomness on `fresh_mask`, four bits for each of the eight S-boxes. The expansion, the key addition and the permutation act on each share on its own. The key is added to the data share only. The S-box stage gives two outputs. The data output is the plain S-box of the masked input, XORed with the fresh bits. The mask output comes from a second function indexed by both the masked input and the input mask, XORed with the same fresh bits. The shares are joined only at the output, where `ciphertext` is the final permutation of their XOR. `done` marks the cycle in which `ciphertext` is valid.

The controller has three states:
- **IDLE**: waits for `start`. The transition **IDLE→RUN (load)** fills both share registers and clears the round counter.
- **RUN**: the transition **RUN→RUN (step)** applies one round and swaps the halves. The transition **RUN→DONE (finish)** applies the last round without the swap.
- **DONE**: the transition **DONE→IDLE (release)** follows unconditionally.

Top module: `mdes_core`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `round_idx` is 0.
- R2: When `done` is 1, `ciphertext` equals standard DES encryption of the plaintext captured at start, using the sixteen keys presented while `round_idx` was 0 through 15.
- R3: If `start` is sampled in IDLE at clock edge E0, `done` is 1 exactly during the cycle after edge E16 and 0 in the cycle that follows.
- R4: `ciphertext` does not depend on `init_mask` or on `fresh_mask`. The same plaintext and keys give the same result with all-zero masks, all-one masks or random masks.
- R5: A `start` pulse while a block is being processed has no effect. Neither the result nor the timing of that block changes.
- R6: In the cycle after the load edge, `round_idx` is 0. It then rises by one each cycle through 15, and each value names the key in use during that cycle.
- R7: Key 0x133457799BBCDFF1 and plaintext 0x0123456789ABCDEF give ciphertext 0x85E813540F0AB405.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a block when sampled in IDLE |
| plaintext | input | 64 | Block to encrypt, sampled with `start` |
| init_mask | input | 64 | Random mask paired with the plaintext, sampled with `start` |
| round_key | input | 48 | Round key for the round named by `round_idx` |
| fresh_mask | input | 32 | New output-mask bits for the eight S-boxes, four bits per box (box 1 in the top nibble), used in the current round |
| round_idx | output | ROUND_W (4) | Index of the round computed in this cycle |
| done | output | 1 | One-cycle strobe: `ciphertext` is valid |
| ciphertext | output | 64 | Unmasked result |

## Verification
The assertions assume that `start` is synchronous and that the round counter rises only in RUN. They also assume the caller changes `round_key` and `fresh_mask` only between clock edges and keeps them valid for the round shown on `round_idx`. The bench drives every input on the falling edge and picks the key from the schedule entry matching the current round. Each new key and fresh word is set up half a period before the edge that uses it. The mask-independence checks reuse one plaintext and key with masks at both extremes and at random values. One run pokes `start` halfway through a block to show that it is ignored.

// File: rtl/mdes_pkg.sv
package mdes_pkg;

    localparam int NBOX = 8;

    // 64 four-bit entries per box, entry 0 in the top nibble, index = row*16 + col
    localparam logic [255:0] SBOX_TBL [NBOX] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    // source bit (1 = MSB) for each output bit of the round permutation
    localparam int P_SRC [32] = '{
        16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
        2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25
    };

    function automatic logic [3:0] sbox_lookup(input int box, input logic [5:0] x);
        logic [5:0] idx;
        idx = {x[5], x[0], x[4:1]};
        return SBOX_TBL[box][255 - 4*int'(idx) -: 4];
    endfunction

    // second table: value that, XORed onto S(y), gives S(y ^ m)
    function automatic logic [3:0] smask_lookup(input int box, input logic [5:0] y,
                                                input logic [5:0] m);
        return sbox_lookup(box, y) ^ sbox_lookup(box, y ^ m);
    endfunction

    function automatic int ip_src(input int r, input int c);
        return ((r < 4) ? (58 + 2*r) : (57 + 2*(r - 4))) - 8*c;
    endfunction

    function automatic logic [63:0] perm_ip(input logic [63:0] x);
        logic [63:0] y;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                y[63 - (8*r + c)] = x[64 - ip_src(r, c)];
        return y;
    endfunction

    function automatic logic [63:0] perm_fp(input logic [63:0] x);
        logic [63:0] y;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                y[64 - ip_src(r, c)] = x[63 - (8*r + c)];
        return y;
    endfunction

    function automatic logic [47:0] expand(input logic [31:0] x);
        logic [47:0] y;
        for (int i = 0; i < 8; i++)
            for (int p = 0; p < 6; p++)
                y[47 - (6*i + p)] = x[32 - (((4*i + p + 31) % 32) + 1)];
        return y;
    endfunction

    function automatic logic [31:0] pperm(input logic [31:0] x);
        logic [31:0] y;
        for (int o = 0; o < 32; o++)
            y[31 - o] = x[32 - P_SRC[o]];
        return y;
    endfunction

endpackage

// File: rtl/mdes_sbox_pair.sv
module mdes_sbox_pair
    import mdes_pkg::*;
#(
    parameter int BOX = 0
) (
    input  logic [5:0] in_d,
    input  logic [5:0] in_m,
    input  logic [3:0] fresh,
    output logic [3:0] out_d,
    output logic [3:0] out_m
);
    always_comb begin
        out_d = sbox_lookup(BOX, in_d) ^ fresh;
        out_m = smask_lookup(BOX, in_d, in_m) ^ fresh;
    end
endmodule

// File: rtl/mdes_round.sv
module mdes_round
    import mdes_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int KEY_W  = 48
) (
    input  logic [HALF_W-1:0] l_d,
    input  logic [HALF_W-1:0] r_d,
    input  logic [HALF_W-1:0] l_m,
    input  logic [HALF_W-1:0] r_m,
    input  logic [KEY_W-1:0]  key,
    input  logic [HALF_W-1:0] fresh,
    input  logic              last_round,
    output logic [HALF_W-1:0] nl_d,
    output logic [HALF_W-1:0] nr_d,
    output logic [HALF_W-1:0] nl_m,
    output logic [HALF_W-1:0] nr_m
);
    localparam int IN_W  = KEY_W / NBOX;
    localparam int OUT_W = HALF_W / NBOX;

    logic [KEY_W-1:0]  e_d, e_m;
    logic [HALF_W-1:0] s_d, s_m, f_d, f_m;

    assign e_d = expand(r_d) ^ key;   // key enters the data share only
    assign e_m = expand(r_m);

    for (genvar b = 0; b < NBOX; b++) begin : g_box
        mdes_sbox_pair #(.BOX(b)) i_box (
            .in_d  (e_d[KEY_W-1-IN_W*b -: IN_W]),
            .in_m  (e_m[KEY_W-1-IN_W*b -: IN_W]),
            .fresh (fresh[HALF_W-1-OUT_W*b -: OUT_W]),
            .out_d (s_d[HALF_W-1-OUT_W*b -: OUT_W]),
            .out_m (s_m[HALF_W-1-OUT_W*b -: OUT_W])
        );
    end

    assign f_d = pperm(s_d);
    assign f_m = pperm(s_m);

    always_comb begin
        if (last_round) begin
            nl_d = l_d ^ f_d;  nr_d = r_d;
            nl_m = l_m ^ f_m;  nr_m = r_m;
        end else begin
            nl_d = r_d;        nr_d = l_d ^ f_d;
            nl_m = r_m;        nr_m = l_m ^ f_m;
        end
    end
endmodule

// File: rtl/mdes_core.sv
module mdes_core
    import mdes_pkg::*;
#(
    parameter int BLK_W  = 64,
    parameter int KEY_W  = 48,
    parameter int ROUNDS = 16,
    localparam int HALF_W  = BLK_W / 2,
    localparam int ROUND_W = $clog2(ROUNDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BLK_W-1:0]   plaintext,
    input  logic [BLK_W-1:0]   init_mask,
    input  logic [KEY_W-1:0]   round_key,
    input  logic [HALF_W-1:0]  fresh_mask,
    output logic [ROUND_W-1:0] round_idx,
    output logic               done,
    output logic [BLK_W-1:0]   ciphertext
);
    localparam logic [ROUND_W-1:0] LAST = ROUND_W'(ROUNDS - 1);

    typedef enum logic [1:0] { ST_IDLE, ST_RUN, ST_DONE } state_e;

    state_e             st_q, st_n;
    logic [ROUND_W-1:0] rnd_q, rnd_n;
    logic [BLK_W-1:0]   dat_q, dat_n;   // masked data share {L,R}
    logic [BLK_W-1:0]   msk_q, msk_n;   // mask share {L,R}

    logic [HALF_W-1:0] nl_d, nr_d, nl_m, nr_m;
    logic              last_round;

    assign last_round = (rnd_q == LAST);

    mdes_round #(.HALF_W(HALF_W), .KEY_W(KEY_W)) i_round (
        .l_d        (dat_q[BLK_W-1:HALF_W]),
        .r_d        (dat_q[HALF_W-1:0]),
        .l_m        (msk_q[BLK_W-1:HALF_W]),
        .r_m        (msk_q[HALF_W-1:0]),
        .key        (round_key),
        .fresh      (fresh_mask),
        .last_round (last_round),
        .nl_d       (nl_d),
        .nr_d       (nr_d),
        .nl_m       (nl_m),
        .nr_m       (nr_m)
    );

    // next-state and datapath selection
    always_comb begin
        st_n  = st_q;
        rnd_n = rnd_q;
        dat_n = dat_q;
        msk_n = msk_q;
        unique case (st_q)
            ST_IDLE: if (start) begin
                st_n  = ST_RUN;
                rnd_n = '0;
                dat_n = perm_ip(plaintext ^ init_mask);
                msk_n = perm_ip(init_mask);
            end
            ST_RUN: begin
                dat_n = {nl_d, nr_d};
                msk_n = {nl_m, nr_m};
                if (last_round) st_n = ST_DONE;
                else            rnd_n = rnd_q + 1'b1;
            end
            ST_DONE: begin
                st_n  = ST_IDLE;
                rnd_n = '0;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            rnd_q <= '0;
            dat_q <= '0;
            msk_q <= '0;
        end else begin
            st_q  <= st_n;
            rnd_q <= rnd_n;
            dat_q <= dat_n;
            msk_q <= msk_n;
        end
    end

    // outputs: shares meet only here
    always_comb begin
        round_idx  = rnd_q;
        done       = (st_q == ST_DONE);
        ciphertext = perm_fp(dat_q ^ msk_q);
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && rnd_q == LAST) |=> done);

    assert_round_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && rnd_q != LAST) |=> (st_q == ST_RUN && rnd_q == $past(rnd_q) + 1'b1));

    assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && start) |=> (st_q != ST_IDLE && rnd_q != '0));

    assert_load_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start) |=> (st_q == ST_RUN && rnd_q == '0));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!done && rnd_q == '0));

endmodule

// File: tb/test_mdes_core.sv
module test_mdes_core;
    import mdes_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] plaintext = '0;
    logic [63:0] init_mask = '0;
    logic [47:0] round_key = '0;
    logic [31:0] fresh_mask = '0;
    logic [3:0]  round_idx;
    logic        done;
    logic [63:0] ciphertext;

    mdes_core i_mdes_core (
        .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
        .init_mask(init_mask), .round_key(round_key), .fresh_mask(fresh_mask),
        .round_idx(round_idx), .done(done), .ciphertext(ciphertext)
    );

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    string cur_tag = "R2";
    logic [63:0] exp_q [$];
    logic [47:0] ks [16];

    localparam int PC1 [56] = '{
        57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18, 10, 2,
        59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36, 63, 55, 47, 39,
        31, 23, 15, 7, 62, 54, 46, 38, 30, 22, 14, 6, 61, 53, 45, 37,
        29, 21, 13, 5, 28, 20, 12, 4
    };
    localparam int PC2 [48] = '{
        14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10, 23, 19, 12, 4,
        26, 8, 16, 7, 27, 20, 13, 2, 41, 52, 31, 37, 47, 55, 30, 40,
        51, 45, 33, 48, 44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };
    localparam int SHIFTS [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic make_schedule(input logic [63:0] key);
        logic [55:0] cd;
        logic [27:0] c, d;
        for (int i = 0; i < 56; i++) cd[55 - i] = key[64 - PC1[i]];
        c = cd[55:28];
        d = cd[27:0];
        for (int r = 0; r < 16; r++) begin
            for (int s = 0; s < SHIFTS[r]; s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            cd = {c, d};
            for (int j = 0; j < 48; j++) ks[r][47 - j] = cd[56 - PC2[j]];
        end
    endtask

    // plain reference: swap every round, swap back before the final permutation
    function automatic logic [63:0] ref_des(input logic [63:0] pt);
        logic [63:0] t;
        logic [31:0] l, r, s, nl;
        logic [47:0] e;
        t = perm_ip(pt);
        l = t[63:32];
        r = t[31:0];
        for (int i = 0; i < 16; i++) begin
            e = expand(r) ^ ks[i];
            for (int b = 0; b < 8; b++) s[31 - 4*b -: 4] = sbox_lookup(b, e[47 - 6*b -: 6]);
            nl = r;
            r = l ^ pperm(s);
            l = nl;
        end
        return perm_fp({r, l});
    endfunction

    // driver: push expectation, start, feed keys and fresh masks
    task automatic run_vec(input logic [63:0] pt, input logic [63:0] key,
                           input logic [63:0] mask, input int fresh_mode,
                           input bit poke, input string tag);
        bit idx_ok = 1'b1;
        logic [3:0] bad_idx = '0;
        make_schedule(key);
        exp_q.push_back(ref_des(pt));
        cur_tag = tag;
        @(negedge clk);
        start = 1'b1;
        plaintext = pt;
        init_mask = mask;
        @(negedge clk);
        start = 1'b0;
        plaintext = {$urandom, $urandom};
        init_mask = {$urandom, $urandom};
        for (int r = 0; r < 16; r++) begin
            if (round_idx != 4'(r)) begin
                idx_ok = 1'b0;
                bad_idx = round_idx;
            end
            round_key = ks[r];
            fresh_mask = (fresh_mode == 0) ? 32'h0 :
                         (fresh_mode == 1) ? 32'hFFFF_FFFF : $urandom;
            start = (poke && r == 5);
            @(negedge clk);
        end
        start = 1'b0;
        chk(idx_ok, "R6 round index", 64'(bad_idx), 64'(0));
        chk(done === 1'b1, "R3 done after round 16", 64'(done), 64'(1));
        @(negedge clk);
        chk(done === 1'b0, "R3 done one cycle wide", 64'(done), 64'(0));
    endtask

    // monitor: compare each result as it appears
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected done", ciphertext, 64'(0));
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(ciphertext === e, cur_tag, ciphertext, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [63:0] pt, key;
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R1 done in reset", 64'(done), 64'(0));
        chk(round_idx === 4'd0, "R1 index in reset", 64'(round_idx), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && round_idx === 4'd0, "R1 after release",
            {done, 59'(0), round_idx}, 64'(0));

        // R7 known answer, reference then engine
        make_schedule(64'h1334_5779_9BBC_DFF1);
        chk(ref_des(64'h0123_4567_89AB_CDEF) === 64'h85E8_1354_0F0A_B405,
            "R7 reference", ref_des(64'h0123_4567_89AB_CDEF), 64'h85E8_1354_0F0A_B405);
        run_vec(64'h0123_4567_89AB_CDEF, 64'h1334_5779_9BBC_DFF1,
                {$urandom, $urandom}, 2, 1'b0, "R7 known answer");

        // R2 random blocks, keys and masks
        for (int v = 0; v < 8; v++)
            run_vec({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                    2, 1'b0, "R2 random block");

        // R4 one block, several mask patterns
        pt  = {$urandom, $urandom};
        key = {$urandom, $urandom};
        run_vec(pt, key, 64'h0, 0, 1'b0, "R4 zero masks");
        run_vec(pt, key, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1'b0, "R4 all-one masks");
        run_vec(pt, key, {$urandom, $urandom}, 2, 1'b0, "R4 random masks");

        // R5 start pulse in mid-run
        run_vec({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                2, 1'b1, "R5 busy start ignored");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all results seen", 64'(exp_q.size()), 64'(0));
        report();
    end
endmodule